// File: doc/BRIEF.md
# Trace Stimulus Port Register Bank

This block is the software-facing front of an instrumentation trace source. Code running on the processor writes data words to any of 32 stimulus ports in a small register window. When the write is allowed, the word goes to a downstream trace FIFO together with the 5-bit number of the port it was written to. A read of any port tells software whether the FIFO still has room, so a polling writer can wait before it sends.

A write to a port is forwarded only if three gates are all open. The master enable bit in the control register must be set, and so must the port's own bit in the enable register. If the access is unprivileged, the privilege mask bit for the port's group of eight must also be clear. Writes to the enable, privilege and control registers are further guarded by a lock. A privileged write of the key word 0xC5ACCE55 to the key register opens the lock, and any other privileged write there closes it again.

The lock is a two-state machine with the states LOCKED (the reset state) and OPEN. It has two transitions. KEY_MATCH is a privileged key-register write carrying the key, and it moves to OPEN. KEY_MISS is a privileged key-register write carrying any other value, and it moves to LOCKED. Every other bus cycle leaves the state where it is.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read. A push is also registered, so `fifo_push` pulses on the cycle after the accepted write. Addresses must be word aligned; an access with address bits [1:0] non-zero matches no register.

Top module: `trace_stim_regs`

## Requirements
- R1: After reset the enable (0xE00), privilege (0xE40) and control (0xE80) registers read 0, the lock status register (0xFB4) reads 0x3, and `fifo_push` is 0.
- R2: A write to port n (offset 4*n, n from 0 to 31) pushes `fifo_data` equal to the write data and `fifo_port` equal to n, with `fifo_push` high for exactly the following cycle. This happens when the master enable (control bit 0) is 1, enable bit n is 1, the FIFO is not full, and the privilege check of R5 passes.
- R3: A port write causes no push when enable bit n is 0 or when the master enable is 0.
- R4: A port write made while `fifo_full` is 1 is dropped: no push follows.
- R5: Privilege mask bit g (privilege register bits [3:0]) covers ports 8g to 8g+7. When that bit is 1, an unprivileged port write to the group causes no push. When it is 0, an unprivileged write is forwarded. Privileged writes ignore the mask.
- R6: A read of any port returns 1 in bit 0 when `fifo_full` is 0 and 0 when it is 1; bits [31:1] read 0.
- R7: A privileged write of 0xC5ACCE55 to 0xFB0 clears lock status bit 1. A privileged write of any other value there sets it again. An unprivileged write to 0xFB0 changes nothing. Lock status bits 0 and 2 always read 1 and 0.
- R8: While status bit 1 is set, writes to the enable, privilege and control registers are ignored.
- R9: Unprivileged writes to the privilege and control registers are ignored.
- R10: An enable register write is ignored while the master enable is 0. An unprivileged enable write updates only the bytes of groups whose mask bit is 0; a privileged one updates all 32 bits.
- R11: Control register bit 23 reads the `fifo_nonempty` input and ignores writes. Only bits [22:16], [9:8] and [4:0] are writable; all other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_priv | input | 1 | 1 for a privileged access |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| fifo_push | output | 1 | Push one entry into the trace FIFO |
| fifo_port | output | 5 | Port number of the pushed entry |
| fifo_data | output | 32 | Data word of the pushed entry |
| fifo_full | input | 1 | Trace FIFO has no room |
| fifo_nonempty | input | 1 | Trace FIFO holds entries still being drained |

## Verification
The hardest situation to reach from the ports is a correct enable register value after an unprivileged write under a mixed privilege mask. Getting there needs a whole chain of privileged writes first: the key unlock, then the master enable, then the mask. The stimulus therefore unlocks, turns on the master bit, sets a mask that restricts groups 0 and 2, and writes all ones as a user, so only the two open bytes may change. Pushes are then tried from ports in a restricted group and in an open group, as both user and privileged. The lock is then closed again to show that the same register writes stop taking effect.

// File: rtl/trace_stim_pkg.sv
package trace_stim_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int NUM_PORTS  = 32;
    localparam int GROUP_SIZE = 8;
    localparam int NUM_GROUPS = NUM_PORTS / GROUP_SIZE;
    localparam int PORT_W     = $clog2(NUM_PORTS);

    localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'hE00;
    localparam logic [ADDR_W-1:0] OFF_PRIV   = 12'hE40;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'hE80;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 12'hFB0;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'hFB4;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
    // writable control bits: id [22:16], prescale [9:8], enables [4:0]
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h007F_031F;
    localparam int CTRL_BUSY_BIT   = 23;
    localparam int CTRL_MASTER_BIT = 0;

    typedef enum logic [0:0] {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/trace_lock_fsm.sv
module trace_lock_fsm
    import trace_stim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_match,
    output logic unlocked
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_match)  state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && !key_match) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/trace_ctrl_regs.sv
module trace_ctrl_regs
    import trace_stim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  priv,
    input  logic                  unlocked,
    output logic [NUM_PORTS-1:0]  enable_q,
    output logic [NUM_GROUPS-1:0] mask_q,
    output logic [DATA_W-1:0]     ctrl_q,
    output logic                  master_en
);
    logic [NUM_PORTS-1:0] byte_wmask;
    logic wr_en, wr_priv, wr_ctrl;

    // per-group write mask for the enable register
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign byte_wmask[g*GROUP_SIZE +: GROUP_SIZE] =
            {GROUP_SIZE{priv || !mask_q[g]}};
    end

    assign master_en = ctrl_q[CTRL_MASTER_BIT];
    assign wr_en   = wr && unlocked && master_en && (addr == OFF_ENABLE);
    assign wr_priv = wr && unlocked && priv && (addr == OFF_PRIV);
    assign wr_ctrl = wr && unlocked && priv && (addr == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mask_q   <= '0;
            ctrl_q   <= '0;
        end else begin
            if (wr_en)
                enable_q <= (enable_q & ~byte_wmask) | (wdata[NUM_PORTS-1:0] & byte_wmask);
            if (wr_priv)
                mask_q <= wdata[NUM_GROUPS-1:0];
            if (wr_ctrl)
                ctrl_q <= wdata & CTRL_WMASK;
        end
    end
endmodule

// File: rtl/trace_stim_gate.sv
module trace_stim_gate
    import trace_stim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  priv,
    input  logic [NUM_PORTS-1:0]  enable_q,
    input  logic [NUM_GROUPS-1:0] mask_q,
    input  logic                  master_en,
    input  logic                  fifo_full,
    output logic                  push_q,
    output logic [PORT_W-1:0]     port_q,
    output logic [DATA_W-1:0]     data_q
);
    localparam int GRP_W = $clog2(NUM_GROUPS);

    logic              stim_hit, accept;
    logic [PORT_W-1:0] idx;
    logic [GRP_W-1:0]  grp;

    assign stim_hit = (addr[ADDR_W-1:PORT_W+2] == '0) && (addr[1:0] == 2'b00);
    assign idx      = addr[PORT_W+1:2];
    assign grp      = idx[PORT_W-1:PORT_W-GRP_W];
    assign accept   = wr && stim_hit && master_en && enable_q[idx]
                      && (priv || !mask_q[grp]) && !fifo_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            port_q <= '0;
            data_q <= '0;
        end else begin
            push_q <= accept;
            if (accept) begin
                port_q <= idx;
                data_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/trace_stim_regs.sv
module trace_stim_regs
    import trace_stim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_priv,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fifo_push,
    output logic [PORT_W-1:0] fifo_port,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_full,
    input  logic              fifo_nonempty
);
    logic                  unlocked, master_en;
    logic [NUM_PORTS-1:0]  enable_q;
    logic [NUM_GROUPS-1:0] mask_q;
    logic [DATA_W-1:0]     ctrl_q;
    logic [DATA_W-1:0]     rd_mux, rdata_q;
    logic                  key_wr;

    assign key_wr = bus_wr && bus_priv && (bus_addr == OFF_KEY);

    trace_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_match(bus_wdata == UNLOCK_KEY), .unlocked(unlocked)
    );

    trace_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .priv(bus_priv), .unlocked(unlocked),
        .enable_q(enable_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
        .master_en(master_en)
    );

    trace_stim_gate u_gate (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .priv(bus_priv), .enable_q(enable_q),
        .mask_q(mask_q), .master_en(master_en), .fifo_full(fifo_full),
        .push_q(fifo_push), .port_q(fifo_port), .data_q(fifo_data)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr[ADDR_W-1:PORT_W+2] == '0 && bus_addr[1:0] == 2'b00)
            rd_mux[0] = !fifo_full;
        else if (bus_addr == OFF_ENABLE)
            rd_mux[NUM_PORTS-1:0] = enable_q;
        else if (bus_addr == OFF_PRIV)
            rd_mux[NUM_GROUPS-1:0] = mask_q;
        else if (bus_addr == OFF_CTRL) begin
            rd_mux = ctrl_q;
            rd_mux[CTRL_BUSY_BIT] = fifo_nonempty;
        end else if (bus_addr == OFF_STATUS)
            rd_mux[2:0] = {1'b0, !unlocked, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/trace_stim_checker.sv
module trace_stim_checker
    import trace_stim_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              fifo_push,
    input logic [PORT_W-1:0] fifo_port,
    input logic [DATA_W-1:0] fifo_data,
    input logic              fifo_full,
    input logic              fifo_nonempty
);
    logic stim_addr;
    assign stim_addr = (bus_addr[ADDR_W-1:PORT_W+2] == '0) && (bus_addr[1:0] == 2'b00);

    // R2
    push_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(bus_wr && stim_addr));

    // R2
    push_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (fifo_data == $past(bus_wdata) && fifo_port == $past(bus_addr[PORT_W+1:2])));

    // R4
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !$past(fifo_full));

    // R6
    stim_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && stim_addr) |=> (bus_rdata == {{(DATA_W-1){1'b0}}, !$past(fifo_full)}));

    // R7
    lock_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_STATUS) |=> (bus_rdata[0] && !bus_rdata[2] && bus_rdata[31:3] == '0));

    // R11
    busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF_CTRL) |=> (bus_rdata[CTRL_BUSY_BIT] == $past(fifo_nonempty)));
endmodule

bind trace_stim_regs trace_stim_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .fifo_push(fifo_push), .fifo_port(fifo_port), .fifo_data(fifo_data),
    .fifo_full(fifo_full), .fifo_nonempty(fifo_nonempty)
);

// File: tb/trace_stim_regs_bench.sv
`timescale 1ns/1ps
module trace_stim_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        fifo_push;
    logic [4:0]  fifo_port;
    logic [31:0] fifo_data;
    logic        fifo_full = 1'b0, fifo_nonempty = 1'b0;

    int checks = 0, errors = 0;
    logic        got_push;
    logic [4:0]  got_port;
    logic [31:0] got_data, rv;

    always #2.5 clk = ~clk;

    trace_stim_regs u_trace_stim_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .fifo_push(fifo_push), .fifo_port(fifo_port),
        .fifo_data(fifo_data), .fifo_full(fifo_full), .fifo_nonempty(fifo_nonempty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
        bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
        @(negedge clk);
        got_push = fifo_push; got_port = fifo_port; got_data = fifo_data;
        bus_wr = 1'b0;
        @(negedge clk);
        if (fifo_push !== 1'b0) got_push = 1'bx;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_priv = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        rd(12'hE00, rv); chk("R1 enable", rv, 32'h0);
        rd(12'hE40, rv); chk("R1 priv", rv, 32'h0);
        rd(12'hE80, rv); chk("R1 ctrl", rv, 32'h0);
        rd(12'hFB4, rv); chk("R1 status", rv, 32'h3);
        chk("R1 push", {31'b0, fifo_push}, 32'h0);
    endtask

    task automatic t_lock();
        wr(12'hE80, 32'h1, 1'b1);
        rd(12'hE80, rv); chk("R8 ctrl while locked", rv, 32'h0);
        wr(12'hFB0, 32'hC5ACCE55, 1'b0);
        rd(12'hFB4, rv); chk("R7 user key ignored", rv, 32'h3);
        wr(12'hFB0, 32'hC5ACCE55, 1'b1);
        rd(12'hFB4, rv); chk("R7 key opens", rv, 32'h1);
        wr(12'hFB0, 32'h0, 1'b0);
        rd(12'hFB4, rv); chk("R7 user miss ignored", rv, 32'h1);
    endtask

    task automatic t_ctrl();
        wr(12'hE00, 32'hFFFF_FFFF, 1'b1);
        rd(12'hE00, rv); chk("R10 enable needs master", rv, 32'h0);
        wr(12'hE80, 32'h1, 1'b0);
        rd(12'hE80, rv); chk("R9 user ctrl ignored", rv, 32'h0);
        wr(12'hE80, 32'hFFFF_FFFF, 1'b1);
        rd(12'hE80, rv); chk("R11 writable bits", rv, 32'h007F_031F);
        fifo_nonempty = 1'b1;
        rd(12'hE80, rv); chk("R11 busy mirrors input", rv, 32'h00FF_031F);
        fifo_nonempty = 1'b0;
        wr(12'hE80, 32'h1, 1'b1);
        wr(12'hE40, 32'h5, 1'b0);
        rd(12'hE40, rv); chk("R9 user priv ignored", rv, 32'h0);
        wr(12'hE40, 32'hFFFF_FFF5, 1'b1);
        rd(12'hE40, rv); chk("R9 priv write", rv, 32'h5);
    endtask

    task automatic t_enable();
        wr(12'hE00, 32'hFFFF_FFFF, 1'b0);
        rd(12'hE00, rv); chk("R10 user byte mask", rv, 32'hFF00_FF00);
        wr(12'hE00, 32'hFFFF_FFFE, 1'b1);
        rd(12'hE00, rv); chk("R10 privileged full", rv, 32'hFFFF_FFFE);
    endtask

    task automatic t_push();
        wr(12'h014, 32'h1234_5678, 1'b1);
        chk("R2 push", {31'b0, got_push}, 32'h1);
        chk("R2 port", {27'b0, got_port}, 32'd5);
        chk("R2 data", got_data, 32'h1234_5678);
        wr(12'h07C, 32'hCAFE_0031, 1'b0);
        chk("R5 user open group push", {31'b0, got_push}, 32'h1);
        chk("R5 port 31", {27'b0, got_port}, 32'd31);
        chk("R5 data", got_data, 32'hCAFE_0031);
        wr(12'h00C, 32'hDEAD_0003, 1'b0);
        chk("R5 user masked group", {31'b0, got_push}, 32'h0);
        wr(12'h00C, 32'hBEEF_0003, 1'b1);
        chk("R5 privileged ignores mask", {31'b0, got_push}, 32'h1);
        chk("R5 data", got_data, 32'hBEEF_0003);
        wr(12'h000, 32'h0000_0001, 1'b1);
        chk("R3 disabled port", {31'b0, got_push}, 32'h0);
    endtask

    task automatic t_full();
        fifo_full = 1'b1;
        wr(12'h014, 32'h5555_AAAA, 1'b1);
        chk("R4 full drop", {31'b0, got_push}, 32'h0);
        rd(12'h014, rv); chk("R6 full status", rv, 32'h0);
        fifo_full = 1'b0;
        rd(12'h040, rv); chk("R6 room status", rv, 32'h1);
    endtask

    task automatic t_master_relock();
        wr(12'hE80, 32'h0, 1'b1);
        wr(12'h014, 32'h7777_0000, 1'b1);
        chk("R3 master off", {31'b0, got_push}, 32'h0);
        wr(12'hFB0, 32'h1234, 1'b1);
        rd(12'hFB4, rv); chk("R7 miss relocks", rv, 32'h3);
        wr(12'hE40, 32'h0, 1'b1);
        rd(12'hE40, rv); chk("R8 priv while locked", rv, 32'h5);
        wr(12'hE80, 32'h1, 1'b1);
        rd(12'hE80, rv); chk("R8 ctrl while relocked", rv, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_ctrl();
        t_enable();
        t_push();
        t_full();
        t_master_relock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule